// File: doc/BRIEF.md
# Constrained Transaction Rule Checker

This block watches a hardware transaction that was opened in constrained mode and enforces the static limits such a transaction must obey. A begin strobe carries the address of the opening instruction. After that, every retired instruction reports its program counter, whether it is a taken relative branch and where it goes, an instruction class, and an optional storage operand given as an address and a byte size. The checker compares each instruction against all of its rules in the same cycle. If any rule is broken, the block raises a one-cycle violation pulse with a 3-bit code for the failed rule and leaves the transaction. The surrounding core turns that pulse into a constraint exception.

The block enforces the following limits:
- an instruction budget;
- a 256-byte code window measured from the opening instruction;
- branches may only go forward;
- a footprint limit of four distinct 32-byte data blocks;
- data may not touch the 4 KiB page or pages that hold the code window;
- each operand must stay inside an 8-byte block, or a 32-byte block for the multiple-register class;
- two forbidden instruction classes.

The block does not track memory conflicts, buffer data or restore state. An end strobe closes a clean transaction and wipes all internal tables.

Top module: `txn_rule_checker`

## Requirements
- R1: A begin strobe sets busy on the next clock, clears the violation code to 0, and restarts the instruction counter and the footprint table. A retire reported in the same cycle as the begin strobe, or while busy is low, is ignored.
- R2: The first 32 instructions retired after a begin pass the count rule. The 33rd raises violation code 1.
- R3: An instruction is in the code window when its PC minus the begin address, taken modulo 2^AW, is below 256. An instruction outside the window raises code 2. This includes a PC below the begin address.
- R4: A branch whose target is greater than its own PC is allowed. A branch whose target is less than or equal to its own PC raises code 3.
- R5: Each operand falls in a 32-byte block, identified by address bits above bit 4. Up to four distinct blocks may be touched, and repeated accesses to a known block are free. An operand in a fifth distinct block raises code 4.
- R6: An operand may not lie in the 4 KiB block that holds the begin address, nor in the one that holds the begin address plus 255. Such an operand raises code 5.
- R7: Operand sizes are 1 to 32 bytes, and bytes addr through addr+size-1 must share one block. For class values 0 (plain), 2 and 3 the block is 8-byte aligned. For class value 1 (multiple-register) it is 32-byte aligned. A crossing raises code 6.
- R8: Class values 2 (storage-to-storage) and 3 (extra general) are forbidden and raise code 7.
- R9: The violation output is a single-cycle pulse, registered one clock after the offending retire. When one instruction breaks several rules, the lowest code is reported. Busy falls with the pulse. The code holds until the next begin, and later retires are ignored.
- R10: An end strobe while busy and without a violation clears busy with no pulse. The next transaction starts with an empty footprint table and a zero count.
- R11: After reset, busy, violation and code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_vld | input | 1 | Constrained transaction opens |
| begin_pc | input | AW | Address of the opening instruction |
| end_vld | input | 1 | Transaction closes normally |
| ret_vld | input | 1 | One instruction retired |
| ret_pc | input | AW | PC of the retired instruction |
| ret_br | input | 1 | Retired instruction is a taken relative branch |
| ret_tgt | input | AW | Branch target |
| ret_cls | input | 2 | Class: 0 plain, 1 multiple-register, 2 storage-to-storage, 3 extra general |
| ret_mem | input | 1 | Instruction has a storage operand |
| ret_addr | input | AW | Operand start address |
| ret_size | input | SZW | Operand size in bytes |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Code of the first violation |
| busy | output | 1 | Transaction being checked |

## Verification
Each rule is first driven right up to its limit and then one step past it. Examples are the 32nd versus the 33rd instruction, offset 252 versus 256, and the fourth versus the fifth data block. These pairs separate an off-by-one boundary from a correct one. Operands are placed on both sides of the 8-byte and 32-byte grains and on both pages of a code window that straddles a page boundary, which tells the two alignment grains and the two page candidates apart.

Instructions that break several rules at once show whether the lowest code wins. Retires after a violation or after an end strobe show whether the state is frozen or cleared.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [2:0] {
    VC_NONE  = 3'd0,
    VC_COUNT = 3'd1,
    VC_SPAN  = 3'd2,
    VC_BACK  = 3'd3,
    VC_FOOT  = 3'd4,
    VC_PAGE  = 3'd5,
    VC_ALIGN = 3'd6,
    VC_CLASS = 3'd7
  } viol_code_e;

  typedef enum logic [1:0] {
    IC_PLAIN = 2'd0,
    IC_MULTI = 2'd1,
    IC_SS    = 2'd2,
    IC_XGEN  = 2'd3
  } insn_class_e;

endpackage

// File: rtl/txc_limit_unit.sv
module txc_limit_unit #(
  parameter int AW         = 32,
  parameter int MAX_INSNS  = 32,
  parameter int SPAN_BYTES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [AW-1:0] base_pc,
  input  logic [AW-1:0] pc,
  input  logic          br,
  input  logic [AW-1:0] tgt,
  output logic          cnt_err,
  output logic          span_err,
  output logic          back_err
);
  localparam int CW = $clog2(MAX_INSNS + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic [AW-1:0] offset;

  assign cnt_err  = (cnt_q == CW'(MAX_INSNS));
  assign offset   = pc - base_pc;
  assign span_err = (offset >= AW'(SPAN_BYTES));
  assign back_err = br && (tgt <= pc);

  assign cnt_en = clr || (step && !cnt_err);

  always_comb begin
    if (clr) cnt_n = '0;
    else     cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R2
  insn_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_INSNS));

endmodule

// File: rtl/txc_operand_unit.sv
module txc_operand_unit #(
  parameter int AW         = 32,
  parameter int SZW        = 6,
  parameter int DW_BYTES   = 8,
  parameter int OCTO_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int SPAN_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chk_en,
  input  logic [AW-1:0]                 base_pc,
  input  logic [AW-1:0]                 addr,
  input  logic [SZW-1:0]                size,
  input  logic                          multi,
  output logic                          align_err,
  output logic                          page_err,
  output logic [AW-$clog2(OCTO_BYTES)-1:0] octo_tag
);
  localparam int DW_SH = $clog2(DW_BYTES);
  localparam int OC_SH = $clog2(OCTO_BYTES);
  localparam int PG_SH = $clog2(PAGE_BYTES);

  logic [AW-1:0] last;
  logic [AW-1:0] code_end;
  logic          dw_cross, oc_cross;
  logic          page_lo_hit, page_hi_hit;

  assign last     = addr + {{(AW-SZW){1'b0}}, size} - AW'(1);
  assign dw_cross = (addr[AW-1:DW_SH] != last[AW-1:DW_SH]);
  assign oc_cross = (addr[AW-1:OC_SH] != last[AW-1:OC_SH]);

  always_comb begin
    if (multi) align_err = oc_cross;
    else       align_err = dw_cross;
  end

  assign code_end    = base_pc + AW'(SPAN_BYTES - 1);
  assign page_lo_hit = (addr[AW-1:PG_SH] == base_pc[AW-1:PG_SH]);
  assign page_hi_hit = (addr[AW-1:PG_SH] == code_end[AW-1:PG_SH]);
  assign page_err    = page_lo_hit || page_hi_hit;

  assign octo_tag = addr[AW-1:OC_SH];

  // R7
  octo_contain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !align_err) |-> (last[AW-1:OC_SH] == octo_tag));

endmodule

// File: rtl/txc_footprint_table.sv
module txc_footprint_table #(
  parameter int TAGW    = 27,
  parameter int ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [TAGW-1:0] tag,
  input  logic            ins_en,
  output logic            hit,
  output logic            full
);
  logic [ENTRIES-1:0] vld_q, vld_n, hit_vec, wr_sel;
  logic [TAGW-1:0]    tag_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign hit_vec[i] = vld_q[i] && (tag_q[i] == tag);
    if (i == 0) begin : g_first
      assign wr_sel[i] = ins_en && !vld_q[i];
    end else begin : g_rest
      assign wr_sel[i] = ins_en && !vld_q[i] && vld_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tag_q[i] <= '0;
      else if (wr_sel[i]) tag_q[i] <= tag;
    end
  end

  assign hit  = |hit_vec;
  assign full = &vld_q;

  always_comb begin
    if (clr) vld_n = '0;
    else     vld_n = vld_q | wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vld_q <= '0;
    else if (clr || ins_en)    vld_q <= vld_n;
  end

  // R5
  foot_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);

  // R5
  foot_ins_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (!hit && !full));

endmodule

// File: rtl/txn_rule_checker.sv
module txn_rule_checker
  import txc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SZW        = 6,
  parameter int MAX_INSNS  = 32,
  parameter int SPAN_BYTES = 256,
  parameter int FOOT_ENTS  = 4,
  parameter int DW_BYTES   = 8,
  parameter int OCTO_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           begin_vld,
  input  logic [AW-1:0]  begin_pc,
  input  logic           end_vld,
  input  logic           ret_vld,
  input  logic [AW-1:0]  ret_pc,
  input  logic           ret_br,
  input  logic [AW-1:0]  ret_tgt,
  input  logic [1:0]     ret_cls,
  input  logic           ret_mem,
  input  logic [AW-1:0]  ret_addr,
  input  logic [SZW-1:0] ret_size,
  output logic           viol,
  output logic [2:0]     viol_code,
  output logic           busy
);
  localparam int TAGW = AW - $clog2(OCTO_BYTES);

  logic          busy_q, busy_n;
  logic          viol_q, viol_n;
  viol_code_e    code_q, code_n, hit_code;
  logic [AW-1:0] base_q;
  logic          acc, mem_chk, fire, clr, ins_en;
  logic          cnt_err, span_err, back_err;
  logic          align_err, page_err, class_err, foot_err;
  logic          f_hit, f_full;
  logic [TAGW-1:0] otag;
  insn_class_e   cls;

  assign cls     = insn_class_e'(ret_cls);
  assign acc     = ret_vld && busy_q && !begin_vld;
  assign mem_chk = acc && ret_mem;
  assign clr     = begin_vld || (end_vld && busy_q);

  txc_limit_unit #(
    .AW(AW), .MAX_INSNS(MAX_INSNS), .SPAN_BYTES(SPAN_BYTES)
  ) u_limit (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(acc),
    .base_pc(base_q), .pc(ret_pc), .br(ret_br), .tgt(ret_tgt),
    .cnt_err(cnt_err), .span_err(span_err), .back_err(back_err)
  );

  txc_operand_unit #(
    .AW(AW), .SZW(SZW), .DW_BYTES(DW_BYTES), .OCTO_BYTES(OCTO_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .SPAN_BYTES(SPAN_BYTES)
  ) u_operand (
    .clk(clk), .rst_n(rst_n), .chk_en(mem_chk),
    .base_pc(base_q), .addr(ret_addr), .size(ret_size),
    .multi(cls == IC_MULTI),
    .align_err(align_err), .page_err(page_err), .octo_tag(otag)
  );

  txc_footprint_table #(
    .TAGW(TAGW), .ENTRIES(FOOT_ENTS)
  ) u_foot (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tag(otag),
    .ins_en(ins_en), .hit(f_hit), .full(f_full)
  );

  assign class_err = (cls == IC_SS) || (cls == IC_XGEN);
  assign foot_err  = !f_hit && f_full;

  // lowest code wins
  always_comb begin
    hit_code = VC_NONE;
    if (acc) begin
      if (cnt_err)                    hit_code = VC_COUNT;
      else if (span_err)              hit_code = VC_SPAN;
      else if (back_err)              hit_code = VC_BACK;
      else if (ret_mem && foot_err)   hit_code = VC_FOOT;
      else if (ret_mem && page_err)   hit_code = VC_PAGE;
      else if (ret_mem && align_err)  hit_code = VC_ALIGN;
      else if (class_err)             hit_code = VC_CLASS;
    end
  end

  assign fire   = (hit_code != VC_NONE);
  assign ins_en = mem_chk && !fire && !f_hit;

  always_comb begin
    busy_n = busy_q;
    code_n = code_q;
    viol_n = fire;
    if (begin_vld) begin
      busy_n = 1'b1;
      code_n = VC_NONE;
    end else if (fire) begin
      busy_n = 1'b0;
      code_n = hit_code;
    end else if (end_vld) begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      viol_q <= 1'b0;
      code_q <= VC_NONE;
    end else begin
      busy_q <= busy_n;
      viol_q <= viol_n;
      if (begin_vld || fire) code_q <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (begin_vld) base_q <= begin_pc;
  end

  assign viol      = viol_q;
  assign viol_code = code_q;
  assign busy      = busy_q;

  // R9
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !viol);

  // R9
  viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> ($past(busy) && $past(ret_vld)));

  // R9
  viol_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (!busy && viol_code != 3'd0));

  // R1
  begin_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    begin_vld |=> (busy && viol_code == 3'd0));

endmodule

// File: tb/txn_rule_checker_test.sv
module txn_rule_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SZW = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           begin_vld, end_vld, ret_vld, ret_br, ret_mem;
  logic [AW-1:0]  begin_pc, ret_pc, ret_tgt, ret_addr;
  logic [1:0]     ret_cls;
  logic [SZW-1:0] ret_size;
  logic           viol, busy;
  logic [2:0]     viol_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_rule_checker uut (
    .clk(clk), .rst_n(rst_n), .begin_vld(begin_vld), .begin_pc(begin_pc),
    .end_vld(end_vld), .ret_vld(ret_vld), .ret_pc(ret_pc), .ret_br(ret_br),
    .ret_tgt(ret_tgt), .ret_cls(ret_cls), .ret_mem(ret_mem),
    .ret_addr(ret_addr), .ret_size(ret_size),
    .viol(viol), .viol_code(viol_code), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic open_txn(input logic [AW-1:0] pc);
    @(negedge clk);
    begin_vld = 1'b1;
    begin_pc  = pc;
    @(posedge clk); #1;
    begin_vld = 1'b0;
  endtask

  task automatic close_txn();
    @(negedge clk);
    end_vld = 1'b1;
    @(posedge clk); #1;
    end_vld = 1'b0;
  endtask

  task automatic retire(input logic [AW-1:0] pc, input logic br,
                        input logic [AW-1:0] tgt, input logic [1:0] cls,
                        input logic mem, input logic [AW-1:0] addr,
                        input int size);
    @(negedge clk);
    ret_vld  = 1'b1;
    ret_pc   = pc;
    ret_br   = br;
    ret_tgt  = tgt;
    ret_cls  = cls;
    ret_mem  = mem;
    ret_addr = addr;
    ret_size = SZW'(size);
    @(posedge clk); #1;
    ret_vld  = 1'b0;
  endtask

  task automatic expect_ok(input string req);
    chk(viol == 1'b0, req, int'(viol), 0);
  endtask

  task automatic expect_viol(input string req, input int code);
    chk(viol == 1'b1 && viol_code == 3'(code) && !busy, req,
        int'(viol_code), code);
  endtask

  task automatic t_reset();
    chk(busy == 0 && viol == 0 && viol_code == 0, "R11", int'(busy), 0);
  endtask

  task automatic t_count();
    open_txn(32'h2000);
    chk(busy == 1 && viol_code == 0, "R1", int'(busy), 1);
    for (int k = 0; k < 32; k++) begin
      retire(32'h2000 + 32'(4*k), 0, 0, 2'd0, 0, 0, 1);
      expect_ok("R2");
    end
    retire(32'h2080, 0, 0, 2'd0, 0, 0, 1);
    expect_viol("R2", 1);
    @(posedge clk); #1;
    chk(viol == 0 && busy == 0, "R9", int'(viol), 0);
    retire(32'h2084, 0, 0, 2'd2, 0, 0, 1);
    chk(viol == 0 && viol_code == 3'd1, "R9", int'(viol_code), 1);
  endtask

  task automatic t_span();
    open_txn(32'h2000);
    retire(32'h20FC, 0, 0, 2'd0, 0, 0, 1);
    expect_ok("R3");
    retire(32'h2100, 0, 0, 2'd0, 0, 0, 1);
    expect_viol("R3", 2);
    open_txn(32'h2000);
    retire(32'h1FFC, 0, 0, 2'd0, 0, 0, 1);
    expect_viol("R3", 2);
  endtask

  task automatic t_branch();
    open_txn(32'h2000);
    retire(32'h2010, 1, 32'h2014, 2'd0, 0, 0, 1);
    expect_ok("R4");
    retire(32'h2014, 1, 32'h2014, 2'd0, 0, 0, 1);
    expect_viol("R4", 3);
    open_txn(32'h2000);
    retire(32'h2020, 1, 32'h2004, 2'd0, 0, 0, 1);
    expect_viol("R4", 3);
  endtask

  task automatic t_footprint();
    open_txn(32'h2000);
    for (int k = 0; k < 4; k++) begin
      retire(32'h2000 + 32'(4*k), 0, 0, 2'd0, 1, 32'h8000 + 32'(32*k), 8);
      expect_ok("R5");
    end
    retire(32'h2010, 0, 0, 2'd0, 1, 32'h8008, 8);
    expect_ok("R5");
    retire(32'h2014, 0, 0, 2'd0, 1, 32'h8080, 8);
    expect_viol("R5", 4);
  endtask

  task automatic t_page();
    open_txn(32'h2F80);
    retire(32'h2F80, 0, 0, 2'd0, 1, 32'h4000, 8);
    expect_ok("R6");
    retire(32'h2F84, 0, 0, 2'd0, 1, 32'h3040, 8);
    expect_viol("R6", 5);
    open_txn(32'h2F80);
    retire(32'h2F80, 0, 0, 2'd0, 1, 32'h2010, 4);
    expect_viol("R6", 5);
  endtask

  task automatic t_align();
    open_txn(32'h2000);
    retire(32'h2000, 0, 0, 2'd0, 1, 32'h8008, 8);
    expect_ok("R7");
    retire(32'h2004, 0, 0, 2'd1, 1, 32'h8004, 16);
    expect_ok("R7");
    retire(32'h2008, 0, 0, 2'd0, 1, 32'h8004, 8);
    expect_viol("R7", 6);
    open_txn(32'h2000);
    retire(32'h2000, 0, 0, 2'd1, 1, 32'h8018, 16);
    expect_viol("R7", 6);
  endtask

  task automatic t_class();
    open_txn(32'h2000);
    retire(32'h2000, 0, 0, 2'd1, 0, 0, 1);
    expect_ok("R8");
    retire(32'h2004, 0, 0, 2'd2, 0, 0, 1);
    expect_viol("R8", 7);
    open_txn(32'h2000);
    retire(32'h2000, 0, 0, 2'd3, 0, 0, 1);
    expect_viol("R8", 7);
  endtask

  task automatic t_priority();
    open_txn(32'h2000);
    retire(32'h2200, 1, 32'h2000, 2'd2, 0, 0, 1);
    expect_viol("R9", 2);
    open_txn(32'h2000);
    retire(32'h2040, 1, 32'h2000, 2'd3, 1, 32'h2004, 8);
    expect_viol("R9", 3);
    repeat (3) @(posedge clk);
    #1;
    chk(viol_code == 3'd3 && !busy, "R9", int'(viol_code), 3);
  endtask

  task automatic t_end();
    open_txn(32'h2000);
    for (int k = 0; k < 4; k++) begin
      retire(32'h2000 + 32'(4*k), 0, 0, 2'd0, 1, 32'h8000 + 32'(32*k), 8);
    end
    close_txn();
    chk(busy == 0 && viol == 0, "R10", int'(busy), 0);
    open_txn(32'h2000);
    for (int k = 0; k < 4; k++) begin
      retire(32'h2000 + 32'(4*k), 0, 0, 2'd0, 1, 32'h9000 + 32'(32*k), 8);
      expect_ok("R10");
    end
    retire(32'h2040, 0, 0, 2'd0, 0, 0, 1);
    expect_ok("R10");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    begin_vld = 1'b1;
    begin_pc  = 32'h2000;
    ret_vld   = 1'b1;
    ret_pc    = 32'h5000;
    ret_cls   = 2'd2;
    ret_mem   = 1'b0;
    ret_br    = 1'b0;
    @(posedge clk); #1;
    begin_vld = 1'b0;
    ret_vld   = 1'b0;
    chk(viol == 0 && busy == 1, "R1", int'(viol), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    begin_vld = 0; end_vld = 0; ret_vld = 0; ret_br = 0; ret_mem = 0;
    begin_pc = 0; ret_pc = 0; ret_tgt = 0; ret_addr = 0;
    ret_cls = 0; ret_size = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_count();
    t_span();
    t_branch();
    t_footprint();
    t_page();
    t_align();
    t_class();
    t_priority();
    t_end();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule